// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synthesizable behavioural model of a single-port synchronous memory on a shared data bus. Reads and writes can follow each other on every clock with no idle cycle in between. A write presents its address and command on one clock edge and its data on the next edge. On that same data edge a new command may be issued. A read returns its word combinationally from the registered address within the cycle that follows the command edge, with no output register stage.

Three chip selects qualify a new command. The polarities are low, high and low. An active-low load strobe chooses between loading a new address and advancing the current one. When the current access is advanced, the two lowest address bits step forward linearly and wrap, and the operation type is kept. An active-low clock enable can freeze the whole block for any number of cycles. The data bus is modelled as separate input, output and drive-enable vectors. The drive enable is governed by the registered operation and by an asynchronous active-low output enable. The word is 18 bits wide and split into two 9-bit lanes. Each lane has its own active-low write select. The address width is a parameter, 8 bits by default, and the memory is cleared by reset.

Top module: `sram_ft`

## Requirements
- R1: While reset is high and after reset is released, the block is deselected: `dq_drive` is 0 and every memory word reads as 0.
- R2: An edge with `clk_en_n`=0, `load_n`=0, `wr_n`=1 and all selects active (`sel_a_n`=0, `sel_b`=1, `sel_c_n`=0) starts a read. In the following cycle `dq_out` shows the word at that address, and `dq_drive` is 1 when `out_en_n` is 0.
- R3: An edge with the same conditions but `wr_n`=0 starts a write. At the next enabled edge `dq_in` is stored at that address, and that edge may itself start another read or write.
- R4: Lane 0 is bits 8:0 and is written only when `lane_wr_n[0]`=0. Lane 1 is bits 17:9 and is written only when `lane_wr_n[1]`=0. Both selects are sampled on the data edge. Lanes that are not selected keep their contents, and `lane_wr_n`=2'b11 changes nothing.
- R5: An edge with `clk_en_n`=1 is ignored. The registered address, the operation and any pending write all hold, nothing is written, and `dq_out` and `dq_drive` keep their values.
- R6: During a write data phase `dq_drive` is 0, whatever the value of `out_en_n`.
- R7: An edge with `load_n`=0 and any select inactive deselects the block, so `dq_drive` is 0 in the next cycle. Advance edges that follow keep the block deselected.
- R8: A read with `out_en_n`=1 is a dummy read. `dq_drive` stays 0, but the address still advances on advance edges. `out_en_n` acts on `dq_drive` without waiting for a clock.
- R9: An edge with `clk_en_n`=0 and `load_n`=1 during an active access increments address bits 1:0 modulo 4 and leaves the upper bits alone. It keeps the read or write type and ignores the selects and `wr_n`.
- R10: A read of an address issued on the data edge of a write to that same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| load_n | input | 1 | Low loads a new command, high advances the current access |
| wr_n | input | 1 | Low selects write, high selects read |
| lane_wr_n | input | 2 | Active-low write select per 9-bit lane |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| addr | input | AW | Word address |
| dq_in | input | 18 | Write data from the bus |
| dq_out | output | 18 | Read data to the bus |
| dq_drive | output | 1 | High while the block drives the bus |

## Verification
The hardest situation to reach is a clock-enable stall that lands on a pending write data phase. A lost or early commit there is invisible unless the stalled data and the released data differ in their lane selects. The bench therefore holds one data word with both lanes selected through two stalled edges. It then releases the stall with a different word and only lane 0 selected. The following read must show the old upper lane and the new lower lane. A second subtle case is the dummy read followed by an advance. There the bench raises the output enable only after the advance edge, which exposes through `dq_out` whether the address moved while the bus was released.

// File: rtl/sram_ft_pkg.sv
package sram_ft_pkg;

    localparam int LANE_W    = 9;
    localparam int NUM_LANES = 2;
    localparam int WORD_W    = LANE_W * NUM_LANES;

    typedef logic [WORD_W-1:0]    word_t;
    typedef logic [NUM_LANES-1:0] lane_mask_t;

    // registered state of the access that owns the current cycle
    typedef struct packed {
        logic active;   // a read or write is in progress
        logic is_wr;    // 1: write data phase, 0: read data phase
    } phase_t;

    localparam phase_t PHASE_IDLE = '{active: 1'b0, is_wr: 1'b0};

    function automatic logic chip_selected(input logic a_n, input logic b, input logic c_n);
        return !a_n && b && !c_n;
    endfunction

    function automatic logic drive_allowed(input phase_t ph, input logic oe_n);
        return ph.active && !ph.is_wr && !oe_n;
    endfunction

endpackage

// File: rtl/sram_ft_ctrl.sv
module sram_ft_ctrl
    import sram_ft_pkg::*;
#(
    parameter int AW         = 8,
    parameter int BURST_BITS = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clk_en_n,
    input  logic          sel_ok,
    input  logic          load_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] cur_addr,
    output phase_t        cur_phase
);

    logic [AW-1:0] step_addr;

    generate
        if (BURST_BITS == 0) begin : g_no_step
            assign step_addr = cur_addr;
        end else begin : g_step
            assign step_addr = {cur_addr[AW-1:BURST_BITS],
                                cur_addr[BURST_BITS-1:0] + BURST_BITS'(1)};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr  <= '0;
            cur_phase <= PHASE_IDLE;
        end else if (!clk_en_n) begin
            if (!load_n) begin
                cur_phase.active <= sel_ok;
                cur_phase.is_wr  <= sel_ok && !wr_n;
                if (sel_ok) begin
                    cur_addr <= addr;
                end
            end else if (cur_phase.active) begin
                cur_addr <= step_addr;
            end
        end
    end

endmodule

// File: rtl/sram_ft_array.sv
module sram_ft_array
    import sram_ft_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          commit,
    input  lane_mask_t    lane_en,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);

    localparam int DEPTH = 1 << AW;

    generate
        for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
            logic [LANE_W-1:0] store [DEPTH];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        store[i] <= '0;
                    end
                end else if (commit && lane_en[g]) begin
                    store[waddr] <= wdata[g*LANE_W +: LANE_W];
                end
            end

            assign rdata[g*LANE_W +: LANE_W] = store[raddr];
        end
    endgenerate

endmodule

// File: rtl/sram_ft_bus.sv
module sram_ft_bus
    import sram_ft_pkg::*;
(
    input  phase_t cur_phase,
    input  logic   out_en_n,
    input  word_t  rdata,
    output word_t  dq_out,
    output logic   dq_drive
);

    assign dq_out   = rdata;
    assign dq_drive = drive_allowed(cur_phase, out_en_n);

endmodule

// File: rtl/sram_ft.sv
module sram_ft
    import sram_ft_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clk_en_n,
    input  logic                sel_a_n,
    input  logic                sel_b,
    input  logic                sel_c_n,
    input  logic                load_n,
    input  logic                wr_n,
    input  logic [NUM_LANES-1:0] lane_wr_n,
    input  logic                out_en_n,
    input  logic [AW-1:0]       addr,
    input  logic [WORD_W-1:0]   dq_in,
    output logic [WORD_W-1:0]   dq_out,
    output logic                dq_drive
);

    localparam int BURST_BITS = 2;

    logic          sel_ok;
    logic [AW-1:0] cur_addr;
    phase_t        cur_phase;
    logic          st_active;
    logic          st_wr;
    logic          commit;
    word_t         rdata;

    assign sel_ok    = chip_selected(sel_a_n, sel_b, sel_c_n);
    assign st_active = cur_phase.active;
    assign st_wr     = cur_phase.is_wr;
    // the data edge of a write is the next enabled edge
    assign commit    = !clk_en_n && st_active && st_wr;

    sram_ft_ctrl #(.AW(AW), .BURST_BITS(BURST_BITS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .clk_en_n (clk_en_n),
        .sel_ok   (sel_ok),
        .load_n   (load_n),
        .wr_n     (wr_n),
        .addr     (addr),
        .cur_addr (cur_addr),
        .cur_phase(cur_phase)
    );

    sram_ft_array #(.AW(AW)) u_array (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .lane_en(~lane_wr_n),
        .waddr  (cur_addr),
        .wdata  (dq_in),
        .raddr  (cur_addr),
        .rdata  (rdata)
    );

    sram_ft_bus u_bus (
        .cur_phase(cur_phase),
        .out_en_n (out_en_n),
        .rdata    (rdata),
        .dq_out   (dq_out),
        .dq_drive (dq_drive)
    );

endmodule

// File: rtl/sram_ft_chk.sv
module sram_ft_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          clk_en_n,
    input logic          sel_a_n,
    input logic          sel_b,
    input logic          sel_c_n,
    input logic          load_n,
    input logic          out_en_n,
    input logic          dq_drive,
    input logic [AW-1:0] cur_addr,
    input logic          st_active,
    input logic          st_wr
);

    localparam int BB = 2;

    // R6: never drive during a write data phase
    assert_no_drive_on_write_R6: assert property (@(posedge clk) disable iff (rst)
        (st_active && st_wr) |-> !dq_drive);

    // R8: drive only while output enable is low
    assert_drive_needs_oe_R8: assert property (@(posedge clk) disable iff (rst)
        dq_drive |-> !out_en_n);

    // R7: deselecting load edge releases the bus next cycle
    assert_desel_release_R7: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !load_n && !(!sel_a_n && sel_b && !sel_c_n)) |=> !dq_drive);

    // R5: a stalled edge holds the registered state
    assert_stall_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (!rst && clk_en_n) |=> ($stable(cur_addr) && $stable(st_active) && $stable(st_wr)));

    // R9: advance steps the low bits, keeps upper bits and operation type
    assert_advance_step_R9: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && load_n && st_active) |=>
        ((cur_addr[BB-1:0] == BB'($past(cur_addr[BB-1:0]) + 1'b1))
         && (cur_addr[AW-1:BB] == $past(cur_addr[AW-1:BB]))
         && $stable(st_wr) && st_active));

endmodule

bind sram_ft sram_ft_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clk_en_n (clk_en_n),
    .sel_a_n  (sel_a_n),
    .sel_b    (sel_b),
    .sel_c_n  (sel_c_n),
    .load_n   (load_n),
    .out_en_n (out_en_n),
    .dq_drive (dq_drive),
    .cur_addr (cur_addr),
    .st_active(st_active),
    .st_wr    (st_wr)
);

// File: tb/sram_ft_tb.sv
module sram_ft_tb;

    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clk_en_n = 1'b0;
    logic          sel_a_n = 1'b1;
    logic          sel_b = 1'b0;
    logic          sel_c_n = 1'b1;
    logic          load_n = 1'b0;
    logic          wr_n = 1'b1;
    logic [1:0]    lane_wr_n = 2'b11;
    logic          out_en_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [17:0]   dq_in = '0;
    logic [17:0]   dq_out;
    logic          dq_drive;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [17:0] ref_mem [DEPTH];

    always #5 clk = ~clk;

    sram_ft #(.AW(AW)) u_dut (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .load_n(load_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
        .out_en_n(out_en_n), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_drive(dq_drive)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cmd_load(input logic is_wr, input logic [AW-1:0] a);
        clk_en_n = 1'b0; load_n = 1'b0;
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
        wr_n = !is_wr; addr = a;
    endtask

    task automatic cmd_desel();
        clk_en_n = 1'b0; load_n = 1'b0;
        sel_a_n = 1'b1; sel_b = 1'b1; sel_c_n = 1'b0;
    endtask

    task automatic cmd_adv();
        clk_en_n = 1'b0; load_n = 1'b1;
    endtask

    task automatic ref_write(input logic [AW-1:0] a, input logic [17:0] d, input logic [1:0] ln);
        if (!ln[0]) ref_mem[a][8:0]  = d[8:0];
        if (!ln[1]) ref_mem[a][17:9] = d[17:9];
    endtask

    task automatic t_reset();
        rst = 1'b1; cmd_desel();
        tick(); tick();
        chk("R1 drive in reset", dq_drive, 0);
        rst = 1'b0;
        cmd_adv(); tick();
        chk("R1 drive after reset", dq_drive, 0);
        cmd_load(0, 8'd5); tick();
        chk("R1 cleared word", dq_out, 0);
    endtask

    task automatic t_back_to_back();
        out_en_n = 1'b0;
        cmd_load(1, 8'd10); tick();
        chk("R6 no drive in write phase", dq_drive, 0);
        dq_in = 18'h1_2345; lane_wr_n = 2'b00; cmd_load(1, 8'd11);
        ref_write(8'd10, 18'h1_2345, 2'b00);
        tick();
        chk("R6 no drive second write", dq_drive, 0);
        dq_in = 18'h2_abcd; cmd_load(0, 8'd10);
        ref_write(8'd11, 18'h2_abcd, 2'b00);
        tick();
        chk("R3 read first write", dq_out, ref_mem[10]);
        chk("R2 drive on read", dq_drive, 1);
        cmd_load(0, 8'd11); tick();
        chk("R3 read second write", dq_out, ref_mem[11]);
        // R10: read issued on the data edge of a write to the same address
        cmd_load(1, 8'd70); tick();
        dq_in = 18'h3_0f0f; cmd_load(0, 8'd70);
        ref_write(8'd70, 18'h3_0f0f, 2'b00);
        tick();
        chk("R10 read after write same address", dq_out, 18'h3_0f0f);
    endtask

    task automatic t_lanes();
        cmd_load(1, 8'd20); tick();
        dq_in = 18'h3_ffff; lane_wr_n = 2'b00; cmd_load(1, 8'd20);
        ref_write(8'd20, 18'h3_ffff, 2'b00); tick();
        dq_in = 18'h0_0000; lane_wr_n = 2'b10; cmd_load(1, 8'd20);
        ref_write(8'd20, 18'h0_0000, 2'b10); tick();
        dq_in = 18'h0_0155; lane_wr_n = 2'b11; cmd_load(0, 8'd20); tick();
        chk("R4 lane0 only write", dq_out, 18'h3_fe00);
        cmd_load(1, 8'd20); tick();
        dq_in = 18'h0_0000; lane_wr_n = 2'b01; cmd_load(0, 8'd20);
        ref_write(8'd20, 18'h0_0000, 2'b01); tick();
        chk("R4 lane1 only write", dq_out, ref_mem[20]);
        chk("R4 lane1 only expected", dq_out, 18'h0_0000);
    endtask

    task automatic t_stall();
        cmd_load(1, 8'd30); tick();
        dq_in = 18'h2_aaaa; lane_wr_n = 2'b00; clk_en_n = 1'b1;
        addr = 8'd99; wr_n = 1'b1;
        tick(); tick();
        chk("R5 stall keeps write phase", dq_drive, 0);
        dq_in = 18'h1_5555; lane_wr_n = 2'b10; cmd_load(0, 8'd30);
        ref_write(8'd30, 18'h1_5555, 2'b10); tick();
        chk("R5 no write during stall", dq_out, 18'h0_0155);
        clk_en_n = 1'b1; addr = 8'd10; wr_n = 1'b0; tick();
        chk("R5 stalled read data held", dq_out, 18'h0_0155);
        chk("R5 stalled read drive held", dq_drive, 1);
    endtask

    task automatic t_desel();
        out_en_n = 1'b0;
        cmd_load(0, 8'd10); tick();
        chk("R2 read drives", dq_drive, 1);
        cmd_desel(); tick();
        chk("R7 deselect releases bus", dq_drive, 0);
        cmd_adv(); sel_a_n = 1'b0; wr_n = 1'b1; tick();
        chk("R7 advance stays deselected", dq_drive, 0);
    endtask

    task automatic t_dummy();
        cmd_load(1, 8'd50); tick();
        dq_in = 18'h0_1111; lane_wr_n = 2'b00; cmd_load(1, 8'd51);
        ref_write(8'd50, 18'h0_1111, 2'b00); tick();
        dq_in = 18'h0_2222; out_en_n = 1'b1; cmd_load(0, 8'd50);
        ref_write(8'd51, 18'h0_2222, 2'b00); tick();
        chk("R8 dummy read no drive", dq_drive, 0);
        cmd_adv(); tick();
        chk("R8 dummy advance no drive", dq_drive, 0);
        out_en_n = 1'b0; #1;
        chk("R8 oe acts asynchronously", dq_drive, 1);
        chk("R8 address advanced in dummy", dq_out, ref_mem[51]);
    endtask

    task automatic t_burst();
        logic [AW-1:0] seq [4];
        seq[0] = 8'd62; seq[1] = 8'd63; seq[2] = 8'd60; seq[3] = 8'd61;
        cmd_load(1, 8'd62); tick();
        for (int i = 0; i < 4; i++) begin
            dq_in = 18'h0_0400 + 18'(i * 7 + 1); lane_wr_n = 2'b00;
            ref_write(seq[i], dq_in, 2'b00);
            if (i < 3) begin
                cmd_adv(); sel_a_n = 1'b1; wr_n = 1'b1;
            end else begin
                cmd_load(0, 8'd62);
            end
            tick();
        end
        for (int i = 0; i < 4; i++) begin
            chk("R9 burst wrap read", dq_out, ref_mem[seq[i]]);
            chk("R9 burst keeps read type", dq_drive, 1);
            cmd_adv(); wr_n = 1'b0; sel_b = 1'b0; tick();
        end
    endtask

    task automatic t_sweep();
        cmd_load(1, 8'd128); tick();
        for (int i = 0; i < 16; i++) begin
            dq_in = 18'(i * 18'h0_1357 + 18'h0_0042); lane_wr_n = 2'b00;
            ref_write(8'(128 + i), dq_in, 2'b00);
            if (i < 15) cmd_load(1, 8'(129 + i));
            else cmd_load(0, 8'd128);
            tick();
        end
        for (int i = 0; i < 16; i++) begin
            chk("R3 sweep readback", dq_out, ref_mem[128 + i]);
            cmd_load(0, 8'(129 + i)); tick();
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        t_reset();
        t_back_to_back();
        t_lanes();
        t_stall();
        t_desel();
        t_dummy();
        t_burst();
        t_sweep();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule